// File: doc/BRIEF.md
# Read/Write Same-ID Ordering Gate

This block sits between a source of read and write requests and the address channels of an AXI4 master port. Each request carries an ID and an address. The block forwards read requests to the AR channel and write requests to the AW channel. It holds a request back while a transaction with the same ID is still in flight in the opposite direction. Requests in the same direction with the same ID flow on, because the slave already returns their responses in order.

For every ID and every direction the block keeps a count of transactions that have been issued but not yet completed. An AR or AW handshake adds one to the count. A read leaves the count when its last data beat is taken on the R channel. A write leaves the count when its response is taken on the B channel. The block only watches the R and B channels and drives neither of them. Each address channel has a single output register, so a request that is waiting for READY stays steady on the bus.

Top module: `rw_order_gate`

## Requirements
- R1: While reset is active, arValid and awValid are low and every count is zero. With nothing outstanding after reset, reqRdReady and reqWrReady are both high.
- R2: Once arValid or awValid is high, it stays high with an unchanged ID and address until the matching READY is sampled high at a rising edge. A READY that rises and falls while VALID is low has no effect.
- R3: A read accepted at an edge (reqRdValid and reqRdReady both high) appears on AR from that edge on, with the same ID and address. Writes behave the same way on AW. While arValid is high reqRdReady is low, and while awValid is high reqWrReady is low.
- R4: A read with ID x is not accepted while a write with ID x is outstanding or waiting on AW. A write with ID x is not accepted while a read with ID x is outstanding or waiting on AR.
- R5: A request is not held back by earlier same-direction requests with the same ID, as long as fewer than MAX_OUT of them are outstanding.
- R6: When MAX_OUT transactions of one ID are outstanding in one direction, further requests of that ID in that direction wait until one completes.
- R7: A read completes only at an R handshake (rValid and rReady both high) with rLast high. Non-last beats, and a last beat without rReady, release nothing.
- R8: A write completes only at a B handshake (bValid and bReady both high).
- R9: If an issue handshake and a completion for the same ID and direction fall on the same edge, the count is left unchanged.
- R10: If a read and a write with the same free ID are offered in the same cycle, only one of them is accepted. The read wins the first such clash after reset, and the winner then alternates from one clash to the next.
- R11: A request that is held back stalls only its own direction. A request in the other direction with a different ID is accepted at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRdValid | input | 1 | Read request offered |
| reqRdReady | output | 1 | Read request accepted this cycle |
| reqRdId | input | ID_W | Read request ID |
| reqRdAddr | input | ADDR_W | Read request address |
| reqWrValid | input | 1 | Write request offered |
| reqWrReady | output | 1 | Write request accepted this cycle |
| reqWrId | input | ID_W | Write request ID |
| reqWrAddr | input | ADDR_W | Write request address |
| arValid | output | 1 | AR channel VALID |
| arReady | input | 1 | AR channel READY |
| arId | output | ID_W | AR channel ID |
| arAddr | output | ADDR_W | AR channel address |
| awValid | output | 1 | AW channel VALID |
| awReady | input | 1 | AW channel READY |
| awId | output | ID_W | AW channel ID |
| awAddr | output | ADDR_W | AW channel address |
| rValid | input | 1 | Observed R channel VALID |
| rReady | input | 1 | Observed R channel READY |
| rLast | input | 1 | Observed R channel last beat |
| rId | input | ID_W | Observed R channel ID |
| bValid | input | 1 | Observed B channel VALID |
| bReady | input | 1 | Observed B channel READY |
| bId | input | ID_W | Observed B channel ID |

## Verification
The main function is exercised with several kinds of traffic:
- Opposite-direction requests with the same ID, which show whether the gate waits for completion.
- Opposite-direction requests with different IDs, which show that only the matching ID is stalled.
- Back-to-back same-direction reads with one ID, which separate free flow from the MAX_OUT limit.
- Read and write with one free ID offered together, which expose the alternating choice between them.

Non-last R beats and responses without READY show that only true completions release an ID. An issue and a completion on the same edge, followed by a count of how many more completions are needed, separates an update that keeps both changes from one that drops either. A long random phase with random READY drops on AR and AW, and legal R and B traffic, is compared on every clock against a behavioural model.

// File: rtl/ordgate_pkg.sv
package ordgate_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldRd;   // load AR output register
    logic ldWr;   // load AW output register
    logic issRd;  // AR handshake
    logic issWr;  // AW handshake
    logic cplRd;  // R last-beat handshake
    logic cplWr;  // B handshake
  } gateStrobe_t;

endpackage

// File: rtl/ordgate_dp.sv
module ordgate_dp
  import ordgate_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 16,
  parameter int MAX_OUT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       stb,
  input  logic [ID_W-1:0]   reqRdId,
  input  logic [ADDR_W-1:0] reqRdAddr,
  input  logic [ID_W-1:0]   reqWrId,
  input  logic [ADDR_W-1:0] reqWrAddr,
  input  logic [ID_W-1:0]   rId,
  input  logic [ID_W-1:0]   bId,
  output logic              arValid,
  output logic [ID_W-1:0]   arId,
  output logic [ADDR_W-1:0] arAddr,
  output logic              awValid,
  output logic [ID_W-1:0]   awId,
  output logic [ADDR_W-1:0] awAddr,
  output logic [(1<<ID_W)-1:0] rdBusy,
  output logic [(1<<ID_W)-1:0] wrBusy,
  output logic [(1<<ID_W)-1:0] rdFull,
  output logic [(1<<ID_W)-1:0] wrFull
);

  localparam int NID   = 1 << ID_W;
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  // address channel output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arValid <= 1'b0;
      arId    <= '0;
      arAddr  <= '0;
    end else if (stb.ldRd) begin
      arValid <= 1'b1;
      arId    <= reqRdId;
      arAddr  <= reqRdAddr;
    end else if (stb.issRd) begin
      arValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awValid <= 1'b0;
      awId    <= '0;
      awAddr  <= '0;
    end else if (stb.ldWr) begin
      awValid <= 1'b1;
      awId    <= reqWrId;
      awAddr  <= reqWrAddr;
    end else if (stb.issWr) begin
      awValid <= 1'b0;
    end
  end

  // outstanding counters, one per ID per direction
  logic [CNT_W-1:0] cntRd [NID];
  logic [CNT_W-1:0] cntWr [NID];

  for (genvar i = 0; i < NID; i++) begin : g_id
    logic incRd, decRd, incWr, decWr;
    assign incRd = stb.issRd && (arId == ID_W'(i));
    assign decRd = stb.cplRd && (rId  == ID_W'(i));
    assign incWr = stb.issWr && (awId == ID_W'(i));
    assign decWr = stb.cplWr && (bId  == ID_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntRd[i] <= '0;
      end else begin
        case ({incRd, decRd})
          2'b10:   cntRd[i] <= cntRd[i] + 1'b1;
          2'b01:   cntRd[i] <= cntRd[i] - 1'b1;
          default: cntRd[i] <= cntRd[i];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntWr[i] <= '0;
      end else begin
        case ({incWr, decWr})
          2'b10:   cntWr[i] <= cntWr[i] + 1'b1;
          2'b01:   cntWr[i] <= cntWr[i] - 1'b1;
          default: cntWr[i] <= cntWr[i];
        endcase
      end
    end

    assign rdBusy[i] = (cntRd[i] != '0);
    assign wrBusy[i] = (cntWr[i] != '0);
    assign rdFull[i] = (cntRd[i] == CNT_MAX);
    assign wrFull[i] = (cntWr[i] == CNT_MAX);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (cntRd[i] <= CNT_MAX) && (cntWr[i] <= CNT_MAX));  // R6
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rstN)
      !(rdBusy[i] && wrBusy[i]));  // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (decRd |-> rdBusy[i]) and (decWr |-> wrBusy[i]));  // R7
  end

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !stb.issRd |=> arValid && $stable(arId) && $stable(arAddr));  // R2
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !stb.issWr |=> awValid && $stable(awId) && $stable(awAddr));  // R2
  AST_AR_NOT_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> !wrBusy[arId]);  // R4
  AST_AW_NOT_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> !rdBusy[awId]);  // R4

endmodule

// File: rtl/ordgate_ctrl.sv
module ordgate_ctrl
  import ordgate_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRdValid,
  input  logic [ID_W-1:0]   reqRdId,
  input  logic              reqWrValid,
  input  logic [ID_W-1:0]   reqWrId,
  input  logic              arValid,
  input  logic              arReady,
  input  logic              awValid,
  input  logic              awReady,
  input  logic [ID_W-1:0]   awId,
  input  logic [ID_W-1:0]   arId,
  input  logic              rValid,
  input  logic              rReady,
  input  logic              rLast,
  input  logic              bValid,
  input  logic              bReady,
  input  logic [(1<<ID_W)-1:0] rdBusy,
  input  logic [(1<<ID_W)-1:0] wrBusy,
  input  logic [(1<<ID_W)-1:0] rdFull,
  input  logic [(1<<ID_W)-1:0] wrFull,
  output gateStrobe_t       stb,
  output logic              reqRdReady,
  output logic              reqWrReady
);

  logic canRd, canWr, clash, favorRd;

  // a direction may load only into an empty output register, with no
  // opposite-direction traffic of the same ID and room in its own count
  assign canRd = !arValid && !wrBusy[reqRdId] && !rdFull[reqRdId]
               && !(awValid && (awId == reqRdId));
  assign canWr = !awValid && !rdBusy[reqWrId] && !wrFull[reqWrId]
               && !(arValid && (arId == reqWrId));

  assign clash = reqRdValid && reqWrValid && (reqRdId == reqWrId) && canRd && canWr;

  assign reqRdReady = canRd && !(clash && !favorRd);
  assign reqWrReady = canWr && !(clash && favorRd);

  always_comb begin
    stb.ldRd  = reqRdValid && reqRdReady;
    stb.ldWr  = reqWrValid && reqWrReady;
    stb.issRd = arValid && arReady;
    stb.issWr = awValid && awReady;
    stb.cplRd = rValid && rReady && rLast;
    stb.cplWr = bValid && bReady;
  end

  // alternating winner for same-ID clashes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      favorRd <= 1'b1;
    else if (clash) favorRd <= !favorRd;
  end

  AST_ONE_PER_ID: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ldRd && stb.ldWr && (reqRdId == reqWrId)));  // R10
  AST_TURN_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    clash && reqRdReady |=> !(clash && reqRdReady));  // R10

endmodule

// File: rtl/rw_order_gate.sv
module rw_order_gate
  import ordgate_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 16,
  parameter int MAX_OUT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRdValid,
  output logic              reqRdReady,
  input  logic [ID_W-1:0]   reqRdId,
  input  logic [ADDR_W-1:0] reqRdAddr,
  input  logic              reqWrValid,
  output logic              reqWrReady,
  input  logic [ID_W-1:0]   reqWrId,
  input  logic [ADDR_W-1:0] reqWrAddr,
  output logic              arValid,
  input  logic              arReady,
  output logic [ID_W-1:0]   arId,
  output logic [ADDR_W-1:0] arAddr,
  output logic              awValid,
  input  logic              awReady,
  output logic [ID_W-1:0]   awId,
  output logic [ADDR_W-1:0] awAddr,
  input  logic              rValid,
  input  logic              rReady,
  input  logic              rLast,
  input  logic [ID_W-1:0]   rId,
  input  logic              bValid,
  input  logic              bReady,
  input  logic [ID_W-1:0]   bId
);

  localparam int NID = 1 << ID_W;

  gateStrobe_t    stb;
  logic [NID-1:0] rdBusy, wrBusy, rdFull, wrFull;

  ordgate_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqRdValid(reqRdValid), .reqRdId(reqRdId),
    .reqWrValid(reqWrValid), .reqWrId(reqWrId),
    .arValid(arValid), .arReady(arReady),
    .awValid(awValid), .awReady(awReady),
    .awId(awId), .arId(arId),
    .rValid(rValid), .rReady(rReady), .rLast(rLast),
    .bValid(bValid), .bReady(bReady),
    .rdBusy(rdBusy), .wrBusy(wrBusy), .rdFull(rdFull), .wrFull(wrFull),
    .stb(stb), .reqRdReady(reqRdReady), .reqWrReady(reqWrReady)
  );

  ordgate_dp #(.ID_W(ID_W), .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqRdId(reqRdId), .reqRdAddr(reqRdAddr),
    .reqWrId(reqWrId), .reqWrAddr(reqWrAddr),
    .rId(rId), .bId(bId),
    .arValid(arValid), .arId(arId), .arAddr(arAddr),
    .awValid(awValid), .awId(awId), .awAddr(awAddr),
    .rdBusy(rdBusy), .wrBusy(wrBusy), .rdFull(rdFull), .wrFull(wrFull)
  );

endmodule

// File: tb/sim_rw_order_gate.sv
`timescale 1ns/1ps
module sim_rw_order_gate;

  localparam int ID_W = 2;
  localparam int ADDR_W = 16;
  localparam int MAXO = 3;
  localparam int NID = 1 << ID_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqRdValid = 0, reqWrValid = 0;
  logic reqRdReady, reqWrReady;
  logic [ID_W-1:0] reqRdId = 0, reqWrId = 0;
  logic [ADDR_W-1:0] reqRdAddr = 0, reqWrAddr = 0;
  logic arValid, awValid;
  logic arReady = 0, awReady = 0;
  logic [ID_W-1:0] arId, awId;
  logic [ADDR_W-1:0] arAddr, awAddr;
  logic rValid = 0, rReady = 0, rLast = 0, bValid = 0, bReady = 0;
  logic [ID_W-1:0] rId = 0, bId = 0;

  always #2.5 clk = ~clk;

  rw_order_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .MAX_OUT(MAXO)) u0 (
    .clk(clk), .rstN(rstN),
    .reqRdValid(reqRdValid), .reqRdReady(reqRdReady), .reqRdId(reqRdId), .reqRdAddr(reqRdAddr),
    .reqWrValid(reqWrValid), .reqWrReady(reqWrReady), .reqWrId(reqWrId), .reqWrAddr(reqWrAddr),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr),
    .awValid(awValid), .awReady(awReady), .awId(awId), .awAddr(awAddr),
    .rValid(rValid), .rReady(rReady), .rLast(rLast), .rId(rId),
    .bValid(bValid), .bReady(bReady), .bId(bId)
  );

  int nChk = 0, nErr = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mRd [NID];
  int mWr [NID];
  bit mArV, mAwV, mFavRd;
  int mArId, mAwId, mArAddr, mAwAddr;

  function automatic void expAcc(output bit eR, output bit eW, output bit eClash);
    bit cR, cW;
    cR = !mArV && mWr[reqRdId] == 0 && mRd[reqRdId] < MAXO && !(mAwV && mAwId == int'(reqRdId));
    cW = !mAwV && mRd[reqWrId] == 0 && mWr[reqWrId] < MAXO && !(mArV && mArId == int'(reqWrId));
    eR = cR;
    eW = cW;
    eClash = reqRdValid && reqWrValid && reqRdId == reqWrId && cR && cW;
    if (eClash) begin
      if (mFavRd) eW = 0; else eR = 0;
    end
  endfunction

  always @(posedge clk) begin
    bit aR, aW, cl;
    if (!rstN) begin
      foreach (mRd[i]) begin mRd[i] = 0; mWr[i] = 0; end
      mArV = 0; mAwV = 0; mFavRd = 1;
    end else begin
      expAcc(aR, aW, cl);
      if (mArV && arReady) begin mRd[mArId]++; mArV = 0; end
      if (mAwV && awReady) begin mWr[mAwId]++; mAwV = 0; end
      if (rValid && rReady && rLast) mRd[rId]--;
      if (bValid && bReady) mWr[bId]--;
      if (aR && reqRdValid) begin mArV = 1; mArId = reqRdId; mArAddr = reqRdAddr; end
      if (aW && reqWrValid) begin mAwV = 1; mAwId = reqWrId; mAwAddr = reqWrAddr; end
      if (cl) mFavRd = !mFavRd;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    bit eR, eW, cl;
    if (rstN && !done) begin
      expAcc(eR, eW, cl);
      check("R4/R6/R10 reqRdReady", reqRdReady, eR);
      check("R4/R6/R10 reqWrReady", reqWrReady, eW);
      check("R2/R3 arValid", arValid, mArV);
      check("R2/R3 awValid", awValid, mAwV);
      if (mArV) begin
        check("R2 arId", arId, mArId);
        check("R2 arAddr", arAddr, mArAddr);
      end
      if (mAwV) begin
        check("R2 awId", awId, mAwId);
        check("R2 awAddr", awAddr, mAwAddr);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChk++;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state
    #1;
    check("R1 arValid in reset", arValid, 0);
    check("R1 awValid in reset", awValid, 0);
    repeat (3) tick();
    rstN = 1;
    tick();
    #1;
    check("R1 reqRdReady idle", reqRdReady, 1);
    check("R1 reqWrReady idle", reqWrReady, 1);

    // R3: read id1 forwarded to AR
    reqRdValid = 1; reqRdId = 1; reqRdAddr = 16'h0100;
    arReady = 1;  // high before VALID, then dropped (R2 tolerance)
    #1 check("R3 read accepted", reqRdReady, 1);
    tick();
    reqRdValid = 0; arReady = 0;
    #1;
    check("R3 arValid", arValid, 1);
    check("R3 arId", arId, 1);
    check("R3 arAddr", arAddr, 16'h0100);

    // R4: write id1 waits while read id1 sits on AR
    reqWrValid = 1; reqWrId = 1; reqWrAddr = 16'h0200;
    #1 check("R4 write blocked by pending AR", reqWrReady, 0);
    tick();
    check("R2 arValid held", arValid, 1);
    arReady = 1;
    tick();
    arReady = 0;
    #1;
    check("R3 arValid cleared after handshake", arValid, 0);
    check("R4 write blocked by outstanding read", reqWrReady, 0);

    // R11: write id2 goes through while id1 is blocked
    reqWrId = 2;
    #1 check("R11 other ID write accepted", reqWrReady, 1);
    tick();
    reqWrValid = 0;
    awReady = 1;
    tick();
    awReady = 0;
    // R4/R8: read id2 blocked until B handshake
    reqRdValid = 1; reqRdId = 2; reqRdAddr = 16'h0300;
    bValid = 1; bId = 2; bReady = 0;
    #1 check("R4 read blocked by outstanding write", reqRdReady, 0);
    tick();
    check("R8 no completion without bReady", reqRdReady, 0);
    bReady = 1;
    tick();
    bValid = 0; bReady = 0;
    #1 check("R8 read released by B handshake", reqRdReady, 1);
    reqRdValid = 0;
    tick();

    // R7: write id1 released only by last read beat with handshake
    reqWrValid = 1; reqWrId = 1;
    rValid = 1; rReady = 1; rId = 1; rLast = 0;
    tick();
    check("R7 non-last beat releases nothing", reqWrReady, 0);
    rLast = 1; rReady = 0;
    tick();
    check("R7 last beat without rReady releases nothing", reqWrReady, 0);
    rReady = 1;
    tick();
    rValid = 0; rReady = 0; rLast = 0;
    #1 check("R7 released by last beat", reqWrReady, 1);
    reqWrValid = 0;
    tick();

    // R5/R6: same-direction same-ID reads flow up to MAX_OUT
    arReady = 1;
    reqRdValid = 1; reqRdId = 0;
    for (int k = 0; k < MAXO; k++) begin
      reqRdAddr = 16'(16'h1000 + k);
      #1 check("R5 same-ID read accepted", reqRdReady, 1);
      tick();
      tick();
    end
    check("R6 read blocked at MAX_OUT", reqRdReady, 0);

    // R9: issue and completion on the same edge
    rValid = 1; rReady = 1; rLast = 1; rId = 0;
    tick();
    rValid = 0;
    #1 check("R6 read released after completion", reqRdReady, 1);
    tick();          // accepted, AR fires on next edge
    rValid = 1;      // completion on the same edge as that AR handshake
    tick();
    rValid = 0;
    check("R9 count unchanged, read room remains", reqRdReady, 1);
    reqRdValid = 0;
    reqWrValid = 1; reqWrId = 0;
    rValid = 1;
    tick();
    rValid = 0;
    #1 check("R9 one read still outstanding", reqWrReady, 0);
    rValid = 1;
    tick();
    rValid = 0; rReady = 0; rLast = 0;
    #1 check("R9 all reads done", reqWrReady, 1);
    reqWrValid = 0;
    tick();

    // R10: clash on a free ID, read wins first, then write
    reqRdValid = 1; reqRdId = 3; reqRdAddr = 16'h3000;
    reqWrValid = 1; reqWrId = 3; reqWrAddr = 16'h3100;
    #1;
    check("R10 read wins first clash", reqRdReady, 1);
    check("R10 write loses first clash", reqWrReady, 0);
    tick();
    reqRdValid = 0; reqWrValid = 0;
    tick();          // AR fires
    rValid = 1; rReady = 1; rLast = 1; rId = 3;
    tick();
    rValid = 0; rReady = 0; rLast = 0;
    reqRdValid = 1; reqWrValid = 1;
    #1;
    check("R10 write wins second clash", reqWrReady, 1);
    check("R10 read loses second clash", reqRdReady, 0);
    tick();
    reqRdValid = 0; reqWrValid = 0;
    awReady = 1;
    tick();
    awReady = 0;
    bValid = 1; bReady = 1; bId = 3;
    tick();
    bValid = 0; bReady = 0;
    arReady = 0;
    tick();

    // random phase, checked every clock against the model
    for (int c = 0; c < 4000; c++) begin
      int ri, bi;
      reqRdValid = 1'($urandom % 2);
      reqRdId    = ID_W'($urandom);
      reqRdAddr  = ADDR_W'($urandom);
      reqWrValid = 1'($urandom % 2);
      reqWrId    = ID_W'($urandom);
      reqWrAddr  = ADDR_W'($urandom);
      arReady    = 1'($urandom % 2);
      awReady    = 1'($urandom % 2);
      ri = int'($urandom % NID);
      if (mRd[ri] > 0) begin
        rValid = 1'($urandom % 2); rId = ID_W'(ri);
        rLast = ($urandom % 3) == 0; rReady = 1'($urandom % 2);
      end else begin
        rValid = 0; rReady = 0; rLast = 0;
      end
      bi = int'($urandom % NID);
      if (mWr[bi] > 0) begin
        bValid = 1'($urandom % 2); bId = ID_W'(bi); bReady = 1'($urandom % 2);
      end else begin
        bValid = 0; bReady = 0;
      end
      tick();
    end
    reqRdValid = 0; reqWrValid = 0;
    rValid = 0; bValid = 0;
    tick();
    finishRun();
  end

endmodule